// File: doc/BRIEF.md
# Register File with In-Place Exchange

This block is a storage array of 2^ADDR_WIDTH words, each DATA_WIDTH bits wide. It has one write port that acts on the rising clock edge and one combinational read port. While the block is idle, the external write address, write data, write enable and read address go straight to the array, so it behaves as a plain register file.

A pulse on `swapReq` while the block is idle exchanges the words held at `addrA` and `addrB`. A small sequencer then owns the array ports for three cycles. In the first cycle it reads location A into a holding register. In the second it copies location B into location A by feeding the read port back to the write port. In the third it writes the held word into location B. `busy` is high for exactly those three cycles. The caller must hold `addrA` and `addrB` steady until `busy` falls.

Top module: `swap_regfile`

## Requirements
- R1: When idle, a high `wrEn` at a rising edge stores `wrData` at `wrAddr`.
- R2: When idle, `rdData` shows the word at `rdAddr` combinationally, with no clock edge in between.
- R3: `swapReq` high at a rising edge while idle makes `busy` high for the next three cycles and then low. With `swapReq` low at an idle edge, `busy` stays low.
- R4: After the third edge of a sequence, the old words of `addrA` and `addrB` have traded places, and no other location has changed.
- R5: While `busy` is high, the external `wrEn`, `wrAddr` and `wrData` have no effect on the array.
- R6: While `busy` is high, `swapReq` is ignored: a sequence is never restarted or extended part-way through.
- R7: When `addrA` equals `addrB`, a sequence leaves every location unchanged.
- R8: With `swapReq` held high, sequences run back to back: the next one starts at the first idle edge. Two sequences on the same pair restore the original contents.
- R9: An active-low `rstN` forces the sequencer to idle at once, without waiting for a clock edge. A sequence cut short before its first write leaves the array unchanged. Reset does not clear the array.
- R10: The first cycle of a sequence performs no array write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| wrEn | input | 1 | External write enable, used only while idle |
| wrAddr | input | ADDR_WIDTH | External write address |
| wrData | input | DATA_WIDTH | External write data |
| rdAddr | input | ADDR_WIDTH | External read address |
| rdData | output | DATA_WIDTH | Read data from the array |
| addrA | input | ADDR_WIDTH | First location of the exchange |
| addrB | input | ADDR_WIDTH | Second location of the exchange |
| swapReq | input | 1 | Exchange request, sampled while idle |
| busy | output | 1 | High while an exchange owns the array |

## Verification
An idle write becomes visible on `rdData` just after the edge that stores it. A read has no latency at all: a new `rdAddr` gives its word before the next edge. `busy` rises at the edge that samples the request and falls at the third edge after it. The exchanged contents can be read right after that third edge. The bench steps a behavioural model of the array and the sequence phase on each rising edge. One nanosecond later it compares `busy` and the idle `rdData` against the model. Readback sweeps drive `rdAddr` on the falling edge and sample one nanosecond later, which keeps every sample clear of the active edge.

// File: rtl/swap_rf_pkg.sv
package swap_rf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GRAB_A = 2'd1,
    ST_MOVE_B = 2'd2,
    ST_PUT_B  = 2'd3
  } swapState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic active;   // sequencer owns the array ports
    logic rdFromA;  // read port addressed by addrA
    logic rdFromB;  // read port addressed by addrB
    logic wrToA;    // write read-port word into addrA
    logic wrToB;    // write held word into addrB
    logic loadTmp;  // capture read-port word into holding register
  } swapCtrl_t;

endpackage

// File: rtl/swap_rf_ctrl.sv
module swap_rf_ctrl
  import swap_rf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      swapReq,
  output swapCtrl_t ctrl
);

  swapState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (swapReq) stateD = ST_GRAB_A;
      ST_GRAB_A: stateD = ST_MOVE_B;
      ST_MOVE_B: stateD = ST_PUT_B;
      ST_PUT_B:  stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl = '0;
    unique case (stateQ)
      ST_GRAB_A: begin
        ctrl.active  = 1'b1;
        ctrl.rdFromA = 1'b1;
        ctrl.loadTmp = 1'b1;
      end
      ST_MOVE_B: begin
        ctrl.active  = 1'b1;
        ctrl.rdFromB = 1'b1;
        ctrl.wrToA   = 1'b1;
      end
      ST_PUT_B: begin
        ctrl.active = 1'b1;
        ctrl.wrToB  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/swap_rf_datapath.sv
module swap_rf_datapath
  import swap_rf_pkg::*;
#(
  parameter int ADDR_WIDTH = 4,
  parameter int DATA_WIDTH = 8
) (
  input  logic                  clk,
  input  swapCtrl_t             ctrl,
  input  logic                  wrEn,
  input  logic [ADDR_WIDTH-1:0] wrAddr,
  input  logic [DATA_WIDTH-1:0] wrData,
  input  logic [ADDR_WIDTH-1:0] rdAddr,
  input  logic [ADDR_WIDTH-1:0] addrA,
  input  logic [ADDR_WIDTH-1:0] addrB,
  output logic [DATA_WIDTH-1:0] rdData,
  output logic                  arrWe,
  output logic [ADDR_WIDTH-1:0] arrWrAddr,
  output logic [ADDR_WIDTH-1:0] arrRdAddr
);

  localparam int DEPTH = 1 << ADDR_WIDTH;

  logic [DATA_WIDTH-1:0] mem [DEPTH];
  logic [DATA_WIDTH-1:0] tmpQ;
  logic [DATA_WIDTH-1:0] rdWord;
  logic [DATA_WIDTH-1:0] arrWrData;

  // read address select
  always_comb begin
    if (ctrl.rdFromA)      arrRdAddr = addrA;
    else if (ctrl.rdFromB) arrRdAddr = addrB;
    else                   arrRdAddr = rdAddr;
  end

  assign rdWord = mem[arrRdAddr];
  assign rdData = rdWord;

  // write port select: external while idle, feedback while swapping
  always_comb begin
    if (ctrl.active) begin
      arrWe     = ctrl.wrToA | ctrl.wrToB;
      arrWrAddr = ctrl.wrToB ? addrB : addrA;
      arrWrData = ctrl.wrToB ? tmpQ : rdWord;
    end else begin
      arrWe     = wrEn;
      arrWrAddr = wrAddr;
      arrWrData = wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (arrWe) mem[arrWrAddr] <= arrWrData;
  end

  always_ff @(posedge clk) begin
    if (ctrl.loadTmp) tmpQ <= rdWord;
  end

endmodule

// File: rtl/swap_regfile.sv
module swap_regfile
  import swap_rf_pkg::*;
#(
  parameter int ADDR_WIDTH = 4,
  parameter int DATA_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_WIDTH-1:0] wrAddr,
  input  logic [DATA_WIDTH-1:0] wrData,
  input  logic [ADDR_WIDTH-1:0] rdAddr,
  output logic [DATA_WIDTH-1:0] rdData,
  input  logic [ADDR_WIDTH-1:0] addrA,
  input  logic [ADDR_WIDTH-1:0] addrB,
  input  logic                  swapReq,
  output logic                  busy
);

  swapCtrl_t             ctrl;
  logic                  arrWe;
  logic [ADDR_WIDTH-1:0] arrWrAddr;
  logic [ADDR_WIDTH-1:0] arrRdAddr;

  swap_rf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .swapReq (swapReq),
    .ctrl    (ctrl)
  );

  swap_rf_datapath #(
    .ADDR_WIDTH (ADDR_WIDTH),
    .DATA_WIDTH (DATA_WIDTH)
  ) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .addrA     (addrA),
    .addrB     (addrB),
    .rdData    (rdData),
    .arrWe     (arrWe),
    .arrWrAddr (arrWrAddr),
    .arrRdAddr (arrRdAddr)
  );

  assign busy = ctrl.active;

endmodule

// File: rtl/swap_regfile_chk.sv
module swap_regfile_chk #(
  parameter int ADDR_WIDTH = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  swapReq,
  input logic                  busy,
  input logic                  wrEn,
  input logic [ADDR_WIDTH-1:0] wrAddr,
  input logic [ADDR_WIDTH-1:0] addrA,
  input logic [ADDR_WIDTH-1:0] addrB,
  input logic                  arrWe,
  input logic [ADDR_WIDTH-1:0] arrWrAddr
);

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swapReq) |=> busy);  // R3

  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !swapReq) |=> !busy);  // R3

  AST_THREE_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(busy, 2)) |=> !busy);  // R6

  AST_RUN_ON: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy)) |=> busy);  // R3

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |-> (arrWe == wrEn && (!wrEn || arrWrAddr == wrAddr)));  // R1

  AST_SWAP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && arrWe) |-> (arrWrAddr == addrA || arrWrAddr == addrB));  // R5

  AST_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy)) |-> !arrWe);  // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    (!rstN) |-> !busy);  // R9

endmodule

bind swap_regfile swap_regfile_chk #(.ADDR_WIDTH(ADDR_WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swapReq   (swapReq),
  .busy      (busy),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .addrA     (addrA),
  .addrB     (addrB),
  .arrWe     (arrWe),
  .arrWrAddr (arrWrAddr)
);

// File: tb/swap_regfile_tb.sv
`timescale 1ns/1ps
module swap_regfile_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [AW-1:0] addrA = '0;
  logic [AW-1:0] addrB = '0;
  logic          swapReq = 1'b0;
  logic          busy;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // behavioural model
  int            phase = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] mdlTmp;
  bit            mdlValid [DEPTH];
  logic [DW-1:0] expMem [DEPTH];

  always #2.5 clk = ~clk;

  swap_regfile #(.ADDR_WIDTH(AW), .DATA_WIDTH(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .addrA(addrA), .addrB(addrB),
    .swapReq(swapReq), .busy(busy)
  );

  initial for (int i = 0; i < DEPTH; i++) mdlValid[i] = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) phase = 0;
    else begin
      case (phase)
        0: begin
          if (wrEn) begin mdl[wrAddr] = wrData; mdlValid[wrAddr] = 1; end
          if (swapReq) phase = 1;
        end
        1: begin mdlTmp = mdl[addrA]; phase = 2; end
        2: begin mdl[addrA] = mdl[addrB]; mdlValid[addrA] = mdlValid[addrB]; phase = 3; end
        default: begin mdl[addrB] = mdlTmp; mdlValid[addrB] = 1; phase = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      check(busy === (phase != 0), rstN ? "R3 busy" : "R9 busy in reset",
            {7'd0, busy}, {7'd0, (phase != 0)});
      if (phase == 0 && rstN && mdlValid[rdAddr])
        check(rdData === mdl[rdAddr], "R2 idle read", rdData, mdl[rdAddr]);
    end
  end

  task automatic dump(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      rdAddr = a[AW-1:0];
      #1;
      check(rdData === expMem[a], req, rdData, expMem[a]);
    end
  endtask

  task automatic swapPair(input int a, input int b);
    logic [DW-1:0] t;
    @(negedge clk);
    addrA = a[AW-1:0]; addrB = b[AW-1:0]; swapReq = 1'b1;
    @(negedge clk);  // now in first step
    swapReq = 1'b0;
    wrEn = 1'b1; wrAddr = a[AW-1:0]; wrData = 8'hEE;  // R5: ignored write
    @(negedge clk);  // second step
    swapReq = 1'b1;  // R6: ignored request
    wrAddr = 4'd5; wrData = 8'hDD;
    @(negedge clk);  // third step
    swapReq = 1'b0; wrEn = 1'b0;
    t = expMem[a]; expMem[a] = expMem[b]; expMem[b] = t;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [DW-1:0] orig [DEPTH];
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R9 reset idle", {7'd0, busy}, 8'd0);
    rstN = 1'b1;

    // R1: fill through the idle write port
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = a[AW-1:0]; wrData = DW'(a * 17 + 5);
      expMem[a] = DW'(a * 17 + 5);
    end
    @(negedge clk); wrEn = 1'b0;
    dump("R1 fill readback");

    // R4 R5 R6 R10: exchange 3 and 12 with noise during busy
    swapPair(3, 12);
    dump("R4 exchange result");
    swapPair(0, 15);
    dump("R4 exchange ends of array");

    // R7: same address on both sides
    swapPair(7, 7);
    dump("R7 equal addresses");

    // R8: held request, two back-to-back sequences restore contents
    for (int a = 0; a < DEPTH; a++) orig[a] = expMem[a];
    @(negedge clk);
    addrA = 4'd1; addrB = 4'd14; swapReq = 1'b1;
    repeat (5) @(negedge clk);
    swapReq = 1'b0;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R8 back to back done", {7'd0, busy}, 8'd0);
    for (int a = 0; a < DEPTH; a++) expMem[a] = orig[a];
    dump("R8 double exchange restores");

    // R9: reset in the second step, before any write
    @(negedge clk);
    addrA = 4'd2; addrB = 4'd9; swapReq = 1'b1;
    @(negedge clk); swapReq = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1 check(busy === 1'b0, "R9 async reset", {7'd0, busy}, 8'd0);
    @(negedge clk); rstN = 1'b1;
    dump("R9 aborted exchange leaves array");

    // R1 again after reset, then a final exchange
    @(negedge clk); wrEn = 1'b1; wrAddr = 4'd6; wrData = 8'h3C; expMem[6] = 8'h3C;
    @(negedge clk); wrEn = 1'b0;
    swapPair(6, 9);
    dump("R4 exchange after reset");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule